// File: doc/BRIEF.md
# Tiered State-Enable Register Bank

This block holds twelve 64-bit state-enable registers for a processor core, arranged in three privilege tiers of four: a machine tier, a hypervisor tier and a supervisor tier. Software reaches them through a single-cycle CSR port. The port carries a request strobe, a write strobe, a 12-bit address and 64-bit write data. It returns 64-bit read data and an illegal-access flag in the same cycle. A write lands at the next rising clock edge.

Each tier limits the tier below it, and the limit is taken from register contents at run time. A hypervisor register can only change the bits that are set in the machine register with the same index. A supervisor register is limited by the hypervisor register with the same index, or by the machine register when the core runs virtualized. The block checks the extension-enable input, the current privilege and the virtualization mode on every access. It refuses any access those inputs do not allow.

Top module: `stateen_bank`

## Requirements
- R1: After reset all twelve registers read as zero.
- R2: A read at 0x30C+i, 0x60C+i or 0x10C+i (i = 0..3) returns the full 64-bit value of register i of the machine, hypervisor or supervisor tier respectively, with the illegal flag low.
- R3: Every write is a masked merge, new = (old & ~mask) | (data & mask). On the machine tier the mask is bit 63 only, so writing all ones leaves 64'h8000_0000_0000_0000.
- R4: The write mask of hypervisor register i is bit 63 ANDed with machine register i. When machine bit 63 is clear, a hypervisor write changes nothing.
- R5: The write mask of supervisor register i is bit 63 ANDed with hypervisor register i when the virtualization input is 0, and with machine register i when it is 1.
- R6: Addresses 0x31C+i and 0x61C+i are the upper halves of machine and hypervisor register i. A write there merges wdata[31:0] into bits 63:32 through the same mask. A read there returns {32'h0, bits 63:32}. The supervisor tier has no upper-half address.
- R7: While the extension-enable input is low, any access to a bank address raises the illegal flag, returns zero read data and changes no register.
- R8: Privilege encoding is 3 = machine, 1 = supervisor, 0 = user. An access raises the illegal flag, returns zero and writes nothing in any of these cases: a machine-tier access below privilege 3; a hypervisor-tier access at privilege 0 or while virtualized; a supervisor-tier access at privilege 0.
- R9: An address outside the bank (for example 0x30B, 0x320 or 0x11D) leaves the illegal flag low, returns zero and changes no register. A register changes only on a legal write to its own address.
- R10: A read in the same cycle as a write to the same address returns the value from before the write. The new value is visible from the next cycle.
- R11: Clearing a machine bit does not clear the matching hypervisor bit, which holds its value. Later writes can no longer change that hypervisor bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_en | input | 1 | Extension enable; low makes every bank access illegal |
| priv | input | 2 | Current privilege: 3 machine, 1 supervisor, 0 user |
| virt | input | 1 | Virtualization mode |
| csr_req | input | 1 | Access request this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data (bits 31:0 only for upper-half addresses) |
| csr_rdata | output | 64 | Read data, combinational |
| csr_illegal | output | 1 | Illegal-access flag, combinational |

## Verification
A read and a write can fall in the same cycle. The combinational read path drives the old register contents while the masked merge for the new value is set up for the coming edge. The bench provokes this by sampling the read data during a write cycle to a register that is known to be zero. It expects zero there and the written value one cycle later. A second overlap comes from a lower-tier write whose mask depends on an upper-tier value written in an earlier cycle. The bench judges this by ordering the upper-tier set and clear operations and comparing each lower-tier read-back against the mask rule.

// File: rtl/stateen_pkg.sv
package stateen_pkg;

   localparam int DATA_W = 64;
   localparam int HALF_W = 32;
   localparam int ADDR_W = 12;
   localparam int SLOT_W = 2;

   localparam logic [1:0] PRV_U = 2'd0;
   localparam logic [1:0] PRV_M = 2'd3;

   // address bits 11:2 of each window; bits 1:0 pick the register index
   localparam logic [ADDR_W-3:0] WIN_M_LO = 10'h0C3;
   localparam logic [ADDR_W-3:0] WIN_M_HI = 10'h0C7;
   localparam logic [ADDR_W-3:0] WIN_H_LO = 10'h183;
   localparam logic [ADDR_W-3:0] WIN_H_HI = 10'h187;
   localparam logic [ADDR_W-3:0] WIN_S_LO = 10'h043;

   localparam logic [DATA_W-1:0] TOP_BIT   = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] UPPER_ONES = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};

   typedef enum logic [1:0] {
      TIER_M    = 2'd0,
      TIER_H    = 2'd1,
      TIER_S    = 2'd2,
      TIER_NONE = 2'd3
   } tier_e;

   typedef struct packed {
      logic              hit;
      tier_e             tier;
      logic [SLOT_W-1:0] idx;
      logic              hi;
      logic              illegal;
   } sel_t;

endpackage

// File: rtl/stateen_decode.sv
module stateen_decode
   import stateen_pkg::*;
#(
   parameter int NREG   = 4,
   parameter bit HYP_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        priv,
   input  logic              virt,
   input  logic              ext_en,
   output sel_t              sel
);

   logic slot_ok;
   logic priv_ok;

   assign slot_ok = (int'(addr[SLOT_W-1:0]) < NREG);

   always_comb begin
      sel      = '0;
      sel.tier = TIER_NONE;
      sel.idx  = addr[SLOT_W-1:0];
      unique case (addr[ADDR_W-1:SLOT_W])
         WIN_M_LO: begin sel.hit = slot_ok; sel.tier = TIER_M; end
         WIN_M_HI: begin sel.hit = slot_ok; sel.tier = TIER_M; sel.hi = 1'b1; end
         WIN_H_LO: begin sel.hit = slot_ok; sel.tier = TIER_H; end
         WIN_H_HI: begin sel.hit = slot_ok; sel.tier = TIER_H; sel.hi = 1'b1; end
         WIN_S_LO: begin sel.hit = slot_ok; sel.tier = TIER_S; end
         default:  sel.hit = 1'b0;
      endcase

      unique case (sel.tier)
         TIER_M:  priv_ok = (priv == PRV_M);
         TIER_H:  priv_ok = HYP_EN && !virt && (priv != PRV_U);
         TIER_S:  priv_ok = (priv != PRV_U);
         default: priv_ok = 1'b0;
      endcase

      sel.illegal = sel.hit && (!ext_en || !priv_ok);
   end

endmodule

// File: rtl/stateen_tier.sv
module stateen_tier
   import stateen_pkg::*;
#(
   parameter int                NREG = 4,
   parameter logic [DATA_W-1:0] BASE = TOP_BIT
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [SLOT_W-1:0]            wr_idx,
   input  logic                         wr_hi,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [NREG-1:0][DATA_W-1:0]  limit,
   output logic [NREG-1:0][DATA_W-1:0]  regs_q
);

   logic [DATA_W-1:0] data_al;
   logic [DATA_W-1:0] half_sel;

   assign data_al  = wr_hi ? {wdata[HALF_W-1:0], {HALF_W{1'b0}}} : wdata;
   assign half_sel = wr_hi ? UPPER_ONES : '1;

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic [DATA_W-1:0] mask;
      assign mask = BASE & limit[i] & half_sel;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[i] <= '0;
         else if (wr_en && (int'(wr_idx) == i))
            regs_q[i] <= (regs_q[i] & ~mask) | (data_al & mask);
      end
   end

   // no write strobe from the bank, no change in this tier
   assert_tier_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/stateen_bank.sv
module stateen_bank
   import stateen_pkg::*;
#(
   parameter int                NREG   = 4,
   parameter bit                HYP_EN = 1'b1,
   parameter logic [DATA_W-1:0] M_BASE = TOP_BIT,
   parameter logic [DATA_W-1:0] H_BASE = TOP_BIT,
   parameter logic [DATA_W-1:0] S_BASE = TOP_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_en,
   input  logic [1:0]        priv,
   input  logic              virt,
   input  logic              csr_req,
   input  logic              csr_we,
   input  logic [11:0]       csr_addr,
   input  logic [63:0]       csr_wdata,
   output logic [63:0]       csr_rdata,
   output logic              csr_illegal
);

   if (NREG < 1 || NREG > 4) begin : g_bad_nreg
      $error("stateen_bank: NREG must lie in 1..4");
   end

   sel_t sel;
   logic legal_wr;
   logic wr_m, wr_h, wr_s;
   logic [NREG-1:0][DATA_W-1:0] m_q, h_q, s_q;
   logic [NREG-1:0][DATA_W-1:0] m_lim, s_lim;
   logic [DATA_W-1:0] full_val;

   stateen_decode #(.NREG(NREG), .HYP_EN(HYP_EN)) u_dec (
      .addr   (csr_addr),
      .priv   (priv),
      .virt   (virt),
      .ext_en (ext_en),
      .sel    (sel)
   );

   assign legal_wr = csr_req && csr_we && sel.hit && !sel.illegal;
   assign wr_m     = legal_wr && (sel.tier == TIER_M);
   assign wr_h     = legal_wr && (sel.tier == TIER_H);
   assign wr_s     = legal_wr && (sel.tier == TIER_S);

   assign m_lim = '1;

   stateen_tier #(.NREG(NREG), .BASE(M_BASE)) u_mtier (
      .clk, .rst_n,
      .wr_en (wr_m), .wr_idx (sel.idx), .wr_hi (sel.hi),
      .wdata (csr_wdata), .limit (m_lim), .regs_q (m_q)
   );

   if (HYP_EN) begin : g_hyp
      stateen_tier #(.NREG(NREG), .BASE(H_BASE)) u_htier (
         .clk, .rst_n,
         .wr_en (wr_h), .wr_idx (sel.idx), .wr_hi (sel.hi),
         .wdata (csr_wdata), .limit (m_q), .regs_q (h_q)
      );
      assign s_lim = virt ? m_q : h_q;
   end else begin : g_nohyp
      assign h_q   = '0;
      assign s_lim = m_q;
   end

   stateen_tier #(.NREG(NREG), .BASE(S_BASE)) u_stier (
      .clk, .rst_n,
      .wr_en (wr_s), .wr_idx (sel.idx), .wr_hi (1'b0),
      .wdata (csr_wdata), .limit (s_lim), .regs_q (s_q)
   );

   always_comb begin
      full_val = '0;
      if (sel.hit) begin
         unique case (sel.tier)
            TIER_M:  full_val = m_q[sel.idx];
            TIER_H:  full_val = h_q[sel.idx];
            TIER_S:  full_val = s_q[sel.idx];
            default: full_val = '0;
         endcase
      end
   end

   assign csr_illegal = csr_req && sel.illegal;
   assign csr_rdata   = (!csr_req || !sel.hit || sel.illegal) ? '0 :
                        sel.hi ? {{HALF_W{1'b0}}, full_val[DATA_W-1:HALF_W]} : full_val;

   assert_ext_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && !ext_en && sel.hit) |-> (csr_illegal && csr_rdata == '0));

   assert_refused_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && csr_illegal) |=> ($stable(m_q) && $stable(h_q) && $stable(s_q)));

   assert_upper_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_req && sel.hi && !csr_illegal) |-> (csr_rdata[DATA_W-1:HALF_W] == '0));

   for (genvar i = 0; i < NREG; i++) begin : g_chk
      assert_h_needs_m_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(h_q[i][DATA_W-1]) |-> $past(m_q[i][DATA_W-1]));
      assert_s_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(s_q[i][DATA_W-1]) |-> $past((virt || !HYP_EN) ? m_q[i][DATA_W-1] : h_q[i][DATA_W-1]));
   end

endmodule

// File: tb/stateen_bank_tb.sv
module stateen_bank_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] B63  = 64'h8000_0000_0000_0000;
   localparam logic [63:0] ONES = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_en = 1'b1;
   logic [1:0]  priv = 2'd3;
   logic        virt = 1'b0;
   logic        csr_req = 1'b0;
   logic        csr_we = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic        csr_illegal;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stateen_bank u_dut (
      .clk, .rst_n, .ext_en, .priv, .virt,
      .csr_req, .csr_we, .csr_addr, .csr_wdata,
      .csr_rdata, .csr_illegal
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one access; rd/ill sampled mid-cycle, write lands at the following edge
   task automatic acc(input logic [11:0] a, input logic we, input logic [63:0] wd,
                      input logic [1:0] p, input logic v, input logic e,
                      output logic [63:0] rd, output logic ill);
      @(negedge clk);
      csr_addr = a; csr_we = we; csr_wdata = wd;
      priv = p; virt = v; ext_en = e; csr_req = 1'b1;
      #1;
      rd = csr_rdata; ill = csr_illegal;
      @(posedge clk);
      #1;
      csr_req = 1'b0; csr_we = 1'b0; ext_en = 1'b1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] wd, input logic [1:0] p, input logic v);
      logic [63:0] rd; logic ill;
      acc(a, 1'b1, wd, p, v, 1'b1, rd, ill);
   endtask

   task automatic rdchk(input string tag, input logic [11:0] a, input logic [1:0] p,
                        input logic v, input logic [63:0] exp);
      logic [63:0] rd; logic ill;
      acc(a, 1'b0, '0, p, v, 1'b1, rd, ill);
      chk({tag, " data"}, rd, exp);
      chk({tag, " illegal"}, {63'b0, ill}, 64'd0);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) begin
         rdchk("R1 machine", 12'h30C + 12'(i), 2'd3, 1'b0, '0);
         rdchk("R1 hyp",     12'h60C + 12'(i), 2'd1, 1'b0, '0);
         rdchk("R1 sup",     12'h10C + 12'(i), 2'd1, 1'b0, '0);
      end
   endtask

   task automatic t_machine;
      logic [63:0] rd; logic ill;
      acc(12'h30D, 1'b1, ONES, 2'd3, 1'b0, 1'b1, rd, ill);
      chk("R10 read during write shows old value", rd, '0);
      rdchk("R3 machine mask bit 63 only", 12'h30D, 2'd3, 1'b0, B63);
      rdchk("R2 neighbour index untouched", 12'h30C, 2'd3, 1'b0, '0);
      wr(12'h30E, ONES, 2'd3, 1'b0);
      rdchk("R3 machine reg 2", 12'h30E, 2'd3, 1'b0, B63);
   endtask

   task automatic t_hyper;
      wr(12'h60C, ONES, 2'd1, 1'b0);
      rdchk("R4 hyp blocked by machine 0", 12'h60C, 2'd1, 1'b0, '0);
      wr(12'h60D, ONES, 2'd1, 1'b0);
      rdchk("R4 hyp allowed by machine 1", 12'h60D, 2'd1, 1'b0, B63);
   endtask

   task automatic t_super;
      wr(12'h10D, ONES, 2'd1, 1'b0);
      rdchk("R5 sup via hyp reg 1", 12'h10D, 2'd1, 1'b0, B63);
      wr(12'h10E, ONES, 2'd1, 1'b0);
      rdchk("R5 sup blocked by hyp 0", 12'h10E, 2'd1, 1'b0, '0);
      wr(12'h10E, ONES, 2'd1, 1'b1);
      rdchk("R5 sup virtualized uses machine", 12'h10E, 2'd1, 1'b1, B63);
      wr(12'h10C, ONES, 2'd1, 1'b1);
      rdchk("R5 sup virtualized blocked", 12'h10C, 2'd1, 1'b1, '0);
   endtask

   task automatic t_high;
      wr(12'h31F, 64'hFFFF_FFFF, 2'd3, 1'b0);
      rdchk("R6 upper read", 12'h31F, 2'd3, 1'b0, 64'h8000_0000);
      rdchk("R6 full read after upper write", 12'h30F, 2'd3, 1'b0, B63);
      wr(12'h31F, 64'h7FFF_FFFF, 2'd3, 1'b0);
      rdchk("R6 upper write clears bit 63", 12'h30F, 2'd3, 1'b0, '0);
      wr(12'h31F, 64'h8000_0000, 2'd3, 1'b0);
      wr(12'h61F, 64'h8000_0000, 2'd1, 1'b0);
      rdchk("R6 hyp full read", 12'h60F, 2'd1, 1'b0, B63);
      rdchk("R6 hyp upper read", 12'h61F, 2'd1, 1'b0, 64'h8000_0000);
      rdchk("R6 no sup upper address", 12'h11C, 2'd1, 1'b0, '0);
   endtask

   task automatic t_ext;
      logic [63:0] rd; logic ill;
      acc(12'h30C, 1'b1, ONES, 2'd3, 1'b0, 1'b0, rd, ill);
      chk("R7 illegal when disabled", {63'b0, ill}, 64'd1);
      chk("R7 data zero when disabled", rd, '0);
      acc(12'h30D, 1'b0, '0, 2'd3, 1'b0, 1'b0, rd, ill);
      chk("R7 read refused", {63'b0, ill}, 64'd1);
      chk("R7 read data hidden", rd, '0);
      rdchk("R7 write dropped", 12'h30C, 2'd3, 1'b0, '0);
   endtask

   task automatic t_priv;
      logic [63:0] rd; logic ill;
      acc(12'h30C, 1'b1, ONES, 2'd1, 1'b0, 1'b1, rd, ill);
      chk("R8 machine tier from S", {63'b0, ill}, 64'd1);
      rdchk("R8 machine write suppressed", 12'h30C, 2'd3, 1'b0, '0);
      acc(12'h60E, 1'b1, ONES, 2'd1, 1'b1, 1'b1, rd, ill);
      chk("R8 hyp tier while virtualized", {63'b0, ill}, 64'd1);
      rdchk("R8 hyp write suppressed", 12'h60E, 2'd1, 1'b0, '0);
      acc(12'h10D, 1'b1, '0, 2'd0, 1'b0, 1'b1, rd, ill);
      chk("R8 sup tier from user", {63'b0, ill}, 64'd1);
      acc(12'h10D, 1'b0, '0, 2'd0, 1'b0, 1'b1, rd, ill);
      chk("R8 user read data hidden", rd, '0);
      rdchk("R8 sup write suppressed", 12'h10D, 2'd1, 1'b0, B63);
   endtask

   task automatic t_unmapped;
      logic [63:0] rd; logic ill;
      acc(12'h30B, 1'b1, ONES, 2'd3, 1'b0, 1'b1, rd, ill);
      chk("R9 below window flag", {63'b0, ill}, 64'd0);
      chk("R9 below window data", rd, '0);
      acc(12'h320, 1'b0, '0, 2'd3, 1'b0, 1'b1, rd, ill);
      chk("R9 above window data", rd, '0);
      wr(12'h11D, '0, 2'd1, 1'b0);
      rdchk("R9 near-miss write ignored", 12'h10D, 2'd1, 1'b0, B63);
   endtask

   task automatic t_clear;
      wr(12'h30D, '0, 2'd3, 1'b0);
      rdchk("R11 machine cleared", 12'h30D, 2'd3, 1'b0, '0);
      rdchk("R11 hyp keeps bit", 12'h60D, 2'd1, 1'b0, B63);
      wr(12'h60D, '0, 2'd1, 1'b0);
      rdchk("R11 hyp bit now frozen", 12'h60D, 2'd1, 1'b0, B63);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_machine();
      t_hyper();
      t_super();
      t_high();
      t_ext();
      t_priv();
      t_unmapped();
      t_clear();
      summary();
      $finish;
   end

endmodule